// File: doc/BRIEF.md
# Parameterized Signed Sum-of-Products Unit

This is a combinational arithmetic block that produces a single result word. The word is the wrap-around sum of a configurable set of multiply terms and a configurable set of plain addend terms. Each term is added to the running total unless its own negate flag is set, in which case it is subtracted. The block has no clock and no state, and the result follows the operand buses directly.

Operands of mixed widths share three packed buses. The A and B buses hold the two factors of every product. The C bus holds the addends. A compile-time table of 16-bit width fields describes each bus, and the first term of each kind sits at the least significant end. Per-term signedness and negation are also compile-time parameters, and the result width is a parameter of its own. The unit is meant to serve as a shared datapath for filters, dot products and address arithmetic whose operand shapes are fixed at build time.

Configurations are checked during elaboration. Elaboration fails when any of the following holds: either term count is below one, a width table or flag vector has the wrong length for its term count, a bus width differs from the sum of its table, or the two signed vectors for the products differ.

Top module: `sop_unit`

## Requirements
- R1: Term i of a bus takes the bits from the sum of the widths of terms 0..i-1 upward. The width of term i is the unsigned value in bits 16*i+15..16*i of that bus's width table. Term 0 occupies the least significant bits. This layout is the same for the A, B and C buses.
- R2: Before any arithmetic, an operand of a signed term is sign-extended to the result width, and an operand of an unsigned term is zero-extended. Bit i of a signed vector set to 1 marks term i as signed.
- R3: Each product equals the extended A operand times the extended B operand, reduced modulo 2^OUT_W.
- R4: When bit i of the product negate vector is 1, product i is subtracted from the result. When the bit is 0, the product is added.
- R5: Each addend, extended per R2, is added to the result. When bit i of the addend negate vector is 1, addend i is subtracted instead.
- R6: The result is the two's-complement sum of all terms, truncated to OUT_W bits with wrap-around. No overflow indication exists.
- R7: When all three buses are zero, the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aBus | input | A_BUS_W | Packed first factors of all products |
| bBus | input | B_BUS_W | Packed second factors of all products |
| cBus | input | C_BUS_W | Packed addend operands |
| result | output | OUT_W | Wrap-around signed sum of all terms |

## Verification
The bound checker assumes the operand buses carry known values and that the configuration passed the elaboration checks. Under those assumptions it compares three things. First, the result against an addend-only sum whenever a whole factor bus is zero. Second, the result's lowest bit against the parity of the terms' lowest bits. Third, an all-zero bus set against a zero result. The stimulus reaches the zero-factor cases on purpose: the zero, placement and addend scenarios drive A or B to all zeros. The randomized phase masks every field to its declared width, so no bit falls outside a term. Two instances with complementary flag settings and different result widths are compared with a bench-side reference model. Between them they cover every pairing of signed and negate flags for products and for addends.

// File: rtl/sop_pkg.sv
`timescale 1ns/1ps
package sop_pkg;
  localparam int FIELD_W   = 16;
  localparam int MAX_TERMS = 32;
  localparam int TBL_W     = FIELD_W * MAX_TERMS;

  // width of term idx taken from a packed width table
  function automatic int widthOf(input logic [TBL_W-1:0] tbl, input int idx);
    return int'(tbl[idx*FIELD_W +: FIELD_W]);
  endfunction

  // bit position where term idx starts: sum of all earlier widths
  function automatic int offsetOf(input logic [TBL_W-1:0] tbl, input int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) acc += widthOf(tbl, k);
    return acc;
  endfunction
endpackage

// File: rtl/sop_unpack.sv
`timescale 1ns/1ps
module sop_unpack
  import sop_pkg::*;
#(
  parameter int NUM   = 2,
  parameter int BUS_W = 8,
  parameter int OUT_W = 16,
  parameter logic [TBL_W-1:0] TBL = '0,
  parameter logic [NUM-1:0] SIGNED = '0
) (
  input  logic [BUS_W-1:0]            bus,
  output logic [NUM-1:0][OUT_W-1:0]   ext
);
  for (genvar i = 0; i < NUM; i++) begin : g_term
    localparam int W   = widthOf(TBL, i);
    localparam int OFF = offsetOf(TBL, i);
    if (W < 1) begin : g_bad_width
      $error("sop_unpack: term %0d has zero width", i);
    end else if (W >= OUT_W) begin : g_trunc
      assign ext[i] = bus[OFF +: OUT_W];
    end else begin : g_extend
      logic fill;
      assign fill   = SIGNED[i] & bus[OFF+W-1];
      assign ext[i] = {{(OUT_W-W){fill}}, bus[OFF +: W]};
    end
  end
endmodule

// File: rtl/sop_lane.sv
`timescale 1ns/1ps
module sop_lane #(
  parameter int OUT_W = 16,
  parameter bit NEG   = 1'b0
) (
  input  logic [OUT_W-1:0] opA,
  input  logic [OUT_W-1:0] opB,
  output logic [OUT_W-1:0] term
);
  logic [OUT_W-1:0] prod;
  assign prod = opA * opB;

  if (NEG) begin : g_sub
    assign term = (~prod) + OUT_W'(1);
  end else begin : g_add
    assign term = prod;
  end
endmodule

// File: rtl/sop_sum.sv
`timescale 1ns/1ps
module sop_sum #(
  parameter int N     = 2,
  parameter int OUT_W = 16
) (
  input  logic [N-1:0][OUT_W-1:0] terms,
  output logic [OUT_W-1:0]        total
);
  always_comb begin
    total = '0;
    for (int i = 0; i < N; i++) total = total + terms[i];
  end
endmodule

// File: rtl/sop_unit.sv
`timescale 1ns/1ps
module sop_unit
  import sop_pkg::*;
#(
  parameter int NUM_PROD = 3,
  parameter int NUM_ADD  = 2,
  parameter int OUT_W    = 24,
  parameter A_WIDTHS      = {16'd12, 16'd5, 16'd8},
  parameter B_WIDTHS      = {16'd4, 16'd7, 16'd8},
  parameter C_WIDTHS      = {16'd16, 16'd10},
  parameter PROD_A_SIGNED = 3'b101,
  parameter PROD_B_SIGNED = 3'b101,
  parameter PROD_NEG      = 3'b010,
  parameter ADD_SIGNED    = 2'b01,
  parameter ADD_NEG       = 2'b10,
  parameter int A_BUS_W  = 25,
  parameter int B_BUS_W  = 19,
  parameter int C_BUS_W  = 26
) (
  input  logic [A_BUS_W-1:0] aBus,
  input  logic [B_BUS_W-1:0] bBus,
  input  logic [C_BUS_W-1:0] cBus,
  output logic [OUT_W-1:0]   result
);
  localparam int NUM_TERMS = NUM_PROD + NUM_ADD;
  localparam logic [TBL_W-1:0] aTbl = TBL_W'(A_WIDTHS);
  localparam logic [TBL_W-1:0] bTbl = TBL_W'(B_WIDTHS);
  localparam logic [TBL_W-1:0] cTbl = TBL_W'(C_WIDTHS);

  // configuration checks at elaboration
  if (NUM_PROD < 1 || NUM_ADD < 1 || NUM_PROD > MAX_TERMS || NUM_ADD > MAX_TERMS) begin : g_err_count
    $error("sop_unit: term counts out of range");
  end
  if ($bits(A_WIDTHS) != FIELD_W*NUM_PROD || $bits(B_WIDTHS) != FIELD_W*NUM_PROD
      || $bits(C_WIDTHS) != FIELD_W*NUM_ADD) begin : g_err_tbl
    $error("sop_unit: width table length mismatch");
  end
  if ($bits(PROD_A_SIGNED) != NUM_PROD || $bits(PROD_B_SIGNED) != NUM_PROD
      || $bits(PROD_NEG) != NUM_PROD || $bits(ADD_SIGNED) != NUM_ADD
      || $bits(ADD_NEG) != NUM_ADD) begin : g_err_flags
    $error("sop_unit: flag vector length mismatch");
  end
  if (PROD_A_SIGNED != PROD_B_SIGNED) begin : g_err_sign
    $error("sop_unit: product signedness differs between A and B");
  end
  if (offsetOf(aTbl, NUM_PROD) != A_BUS_W || offsetOf(bTbl, NUM_PROD) != B_BUS_W
      || offsetOf(cTbl, NUM_ADD) != C_BUS_W) begin : g_err_bus
    $error("sop_unit: bus width differs from width table sum");
  end

  logic [NUM_PROD-1:0][OUT_W-1:0] extA;
  logic [NUM_PROD-1:0][OUT_W-1:0] extB;
  logic [NUM_ADD-1:0][OUT_W-1:0]  extC;
  logic [NUM_TERMS-1:0][OUT_W-1:0] termVals;

  sop_unpack #(.NUM(NUM_PROD), .BUS_W(A_BUS_W), .OUT_W(OUT_W), .TBL(aTbl),
               .SIGNED(PROD_A_SIGNED)) u_unpackA (.bus(aBus), .ext(extA));
  sop_unpack #(.NUM(NUM_PROD), .BUS_W(B_BUS_W), .OUT_W(OUT_W), .TBL(bTbl),
               .SIGNED(PROD_B_SIGNED)) u_unpackB (.bus(bBus), .ext(extB));
  sop_unpack #(.NUM(NUM_ADD), .BUS_W(C_BUS_W), .OUT_W(OUT_W), .TBL(cTbl),
               .SIGNED(ADD_SIGNED)) u_unpackC (.bus(cBus), .ext(extC));

  for (genvar i = 0; i < NUM_PROD; i++) begin : g_prod
    sop_lane #(.OUT_W(OUT_W), .NEG(PROD_NEG[i])) u_lane (
      .opA(extA[i]), .opB(extB[i]), .term(termVals[i]));
  end
  for (genvar j = 0; j < NUM_ADD; j++) begin : g_add
    sop_lane #(.OUT_W(OUT_W), .NEG(ADD_NEG[j])) u_lane (
      .opA(extC[j]), .opB(OUT_W'(1)), .term(termVals[NUM_PROD+j]));
  end

  sop_sum #(.N(NUM_TERMS), .OUT_W(OUT_W)) u_sum (.terms(termVals), .total(result));
endmodule

// File: rtl/sop_unit_chk.sv
`timescale 1ns/1ps
module sop_unit_chk
  import sop_pkg::*;
#(
  parameter int NUM_PROD = 3,
  parameter int NUM_ADD  = 2,
  parameter int OUT_W    = 24,
  parameter A_WIDTHS      = {16'd12, 16'd5, 16'd8},
  parameter B_WIDTHS      = {16'd4, 16'd7, 16'd8},
  parameter C_WIDTHS      = {16'd16, 16'd10},
  parameter PROD_A_SIGNED = 3'b101,
  parameter ADD_SIGNED    = 2'b01,
  parameter ADD_NEG       = 2'b10,
  parameter int A_BUS_W  = 25,
  parameter int B_BUS_W  = 19,
  parameter int C_BUS_W  = 26
) (
  input logic [A_BUS_W-1:0] aBus,
  input logic [B_BUS_W-1:0] bBus,
  input logic [C_BUS_W-1:0] cBus,
  input logic [OUT_W-1:0]   result
);
  localparam logic [TBL_W-1:0] aTbl = TBL_W'(A_WIDTHS);
  localparam logic [TBL_W-1:0] bTbl = TBL_W'(B_WIDTHS);
  localparam logic [TBL_W-1:0] cTbl = TBL_W'(C_WIDTHS);

  logic [OUT_W-1:0] addOnly;
  logic             lsbParity;

  always_comb begin
    addOnly   = '0;
    lsbParity = 1'b0;
    for (int i = 0; i < NUM_ADD; i++) begin
      int w;
      int off;
      logic [OUT_W-1:0] v;
      w   = widthOf(cTbl, i);
      off = offsetOf(cTbl, i);
      for (int k = 0; k < OUT_W; k++) begin
        if (k < w) v[k] = cBus[off+k];
        else       v[k] = ADD_SIGNED[i] & cBus[off+w-1];
      end
      addOnly   = ADD_NEG[i] ? addOnly - v : addOnly + v;
      lsbParity = lsbParity ^ cBus[off];
    end
    for (int i = 0; i < NUM_PROD; i++) begin
      lsbParity = lsbParity ^ (aBus[offsetOf(aTbl, i)] & bBus[offsetOf(bTbl, i)]);
    end
  end

  always_comb begin
    p_zero_in_zero_out_r7: assert (!(aBus == '0 && bBus == '0 && cBus == '0) || result == '0)
      else $error("zero operands gave nonzero result");
    p_a_zero_addends_r5: assert (aBus != '0 || result == addOnly)
      else $error("A bus zero but result differs from addend sum");
    p_b_zero_addends_r2: assert (bBus != '0 || result == addOnly)
      else $error("B bus zero but result differs from addend sum");
    p_lsb_parity_r3: assert (result[0] == lsbParity)
      else $error("result LSB differs from term LSB parity");
  end
endmodule

bind sop_unit sop_unit_chk #(
  .NUM_PROD(NUM_PROD), .NUM_ADD(NUM_ADD), .OUT_W(OUT_W),
  .A_WIDTHS(A_WIDTHS), .B_WIDTHS(B_WIDTHS), .C_WIDTHS(C_WIDTHS),
  .PROD_A_SIGNED(PROD_A_SIGNED), .ADD_SIGNED(ADD_SIGNED), .ADD_NEG(ADD_NEG),
  .A_BUS_W(A_BUS_W), .B_BUS_W(B_BUS_W), .C_BUS_W(C_BUS_W)
) u_chk (.aBus(aBus), .bBus(bBus), .cBus(cBus), .result(result));

// File: tb/sim_sop_unit.sv
`timescale 1ns/1ps
module sim_sop_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;   // 250 MHz

  logic [24:0] aBus = '0;
  logic [18:0] bBus = '0;
  logic [25:0] cBus = '0;
  logic [23:0] y0;
  logic [15:0] y1;

  // instance 0: default flags, 24-bit result
  sop_unit u0 (.aBus(aBus), .bBus(bBus), .cBus(cBus), .result(y0));

  // instance 1: complementary flags, 16-bit result
  sop_unit #(
    .OUT_W(16), .PROD_A_SIGNED(3'b010), .PROD_B_SIGNED(3'b010), .PROD_NEG(3'b011),
    .ADD_SIGNED(2'b10), .ADD_NEG(2'b10)
  ) u1 (.aBus(aBus), .bBus(bBus), .cBus(cBus), .result(y1));

  int AW[3] = '{8, 5, 12};
  int BW[3] = '{8, 7, 4};
  int CW[2] = '{10, 16};
  longint fa[3];
  longint fb[3];
  longint fc[2];

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  function automatic longint mask(int w);
    return (longint'(1) << w) - 1;
  endfunction

  function automatic longint extVal(longint v, int w, bit s);
    longint m;
    m = v & mask(w);
    if (s && m[w-1]) return m - (longint'(1) << w);
    return m;
  endfunction

  function automatic longint model(bit [2:0] ps, bit [2:0] pn, bit [1:0] cs, bit [1:0] cn, int outw);
    longint acc;
    longint t;
    acc = 0;
    for (int i = 0; i < 3; i++) begin
      t = extVal(fa[i], AW[i], ps[i]) * extVal(fb[i], BW[i], ps[i]);
      acc = pn[i] ? acc - t : acc + t;
    end
    for (int i = 0; i < 2; i++) begin
      t = extVal(fc[i], CW[i], cs[i]);
      acc = cn[i] ? acc - t : acc + t;
    end
    return acc & mask(outw);
  endfunction

  task automatic clearFields();
    for (int i = 0; i < 3; i++) begin fa[i] = 0; fb[i] = 0; end
    for (int i = 0; i < 2; i++) fc[i] = 0;
  endtask

  task automatic drive();
    int off;
    @(posedge clk);
    off = 0;
    for (int i = 0; i < 3; i++) begin
      for (int k = 0; k < AW[i]; k++) aBus[off+k] = fa[i][k];
      off += AW[i];
    end
    off = 0;
    for (int i = 0; i < 3; i++) begin
      for (int k = 0; k < BW[i]; k++) bBus[off+k] = fb[i][k];
      off += BW[i];
    end
    off = 0;
    for (int i = 0; i < 2; i++) begin
      for (int k = 0; k < CW[i]; k++) cBus[off+k] = fc[i][k];
      off += CW[i];
    end
    @(negedge clk);
  endtask

  task automatic check(string tag, longint got, longint exp);
    nChecks++;
    if (got != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic checkBoth(string tag);
    check({tag, " u0"}, longint'(y0), model(3'b101, 3'b010, 2'b01, 2'b10, 24));
    check({tag, " u1"}, longint'(y1), model(3'b010, 3'b011, 2'b10, 2'b10, 16));
  endtask

  task automatic t_zero();
    clearFields();
    drive();
    check("R7 zero u0", longint'(y0), 0);
    check("R7 zero u1", longint'(y1), 0);
  endtask

  task automatic t_placement();
    for (int p = 0; p < 3; p++) begin
      clearFields();
      fa[p] = 3; fb[p] = 2;
      drive();
      checkBoth($sformatf("R1 product %0d placement", p));
    end
    for (int q = 0; q < 2; q++) begin
      clearFields();
      fc[q] = 5;
      drive();
      checkBoth($sformatf("R1 addend %0d placement", q));
    end
  endtask

  task automatic t_extend();
    clearFields();
    for (int i = 0; i < 3; i++) begin fa[i] = mask(AW[i]); fb[i] = 1; end
    for (int i = 0; i < 2; i++) fc[i] = mask(CW[i]);
    drive();
    checkBoth("R2 all-ones operands");
    clearFields();
    for (int i = 0; i < 3; i++) begin
      fa[i] = longint'(1) << (AW[i]-1);
      fb[i] = longint'(1) << (BW[i]-1);
    end
    for (int i = 0; i < 2; i++) fc[i] = longint'(1) << (CW[i]-1);
    drive();
    checkBoth("R2 msb-only operands");
    clearFields();
    for (int i = 0; i < 3; i++) begin fa[i] = mask(AW[i]); fb[i] = mask(BW[i]); end
    drive();
    checkBoth("R2 all-ones factors");
  endtask

  task automatic t_product();
    clearFields();
    fa = '{100, 9, 1000}; fb = '{50, 3, 7};
    drive();
    checkBoth("R3 mixed products");
  endtask

  task automatic t_negate();
    clearFields();
    fa[1] = 7; fb[1] = 9;
    drive();
    check("R4 negated product u0", longint'(y0), 64'hFFFFC1);
    check("R4 negated product u1", longint'(y1), 64'hFFC1);
  endtask

  task automatic t_addend();
    clearFields();
    fc[0] = 300; fc[1] = 1000;
    drive();
    check("R5 addends u0", longint'(y0), 64'hFFFD44);
    check("R5 addends u1", longint'(y1), 64'hFD44);
  endtask

  task automatic t_wrap();
    clearFields();
    fa[2] = 4095; fb[2] = 15; fc[0] = 1023; fc[1] = 64'h8000;
    drive();
    check("R6 wrap u0", longint'(y0), 64'hFF8000);
    check("R6 wrap u1", longint'(y1), 64'h73F0);
  endtask

  task automatic t_random();
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < 3; i++) begin
        fa[i] = longint'($urandom()) & mask(AW[i]);
        fb[i] = longint'($urandom()) & mask(BW[i]);
      end
      for (int i = 0; i < 2; i++) fc[i] = longint'($urandom()) & mask(CW[i]);
      drive();
      checkBoth("R3 R4 R5 R6 random");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_zero();
    t_placement();
    t_extend();
    t_product();
    t_negate();
    t_addend();
    t_wrap();
    t_random();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule